// File: doc/BRIEF.md
# Size-Throttled Request Admission Gate

This block guards the request side of a simple memory target. Each cycle it looks at one offered request (valid, command, byte count, a "supplied elsewhere" flag and a "wants a reply" flag) and decides at once, through `req_accept`, whether to take it. A taken read or write makes the gate busy for a stretch of cycles that grows with the byte count. The stretch is the byte count times the parameter `CPB`, and it is capped at the largest value the countdown register can hold. Control and message commands are taken without any busy time. A taken request that wants a reply is handed to the response path in the same cycle.

A requester that is turned away because the gate is busy is recorded as waiting. When the busy stretch ends, the gate spends exactly one cycle raising `retry_pulse`. During that cycle it still refuses ordinary requests, because the retry has been promised to the requester that was waiting. A request whose data will be supplied by another agent is always taken at once. It is not forwarded and it starts no busy time.

Top module: `throttle_admit`

## Requirements
- R1: `req_accept` is high exactly when `req_valid` is high and either `req_inhibit` is high, or `busy` is low and no retry is outstanding.
- R2: An accepted, non-inhibited read (`req_cmd`=0) or write (`req_cmd`=1) with a nonzero duration raises `busy` from the next cycle on, for exactly that many cycles.
- R3: The duration is `req_size`×`CPB`. When that product exceeds 2^`CNT_W`−1, the duration is 2^`CNT_W`−1.
- R4: A read or write whose duration is zero (for example `req_size`=0) is accepted and leaves `busy` low.
- R5: An accepted control (`req_cmd`=2) or message (`req_cmd`=3) command leaves `busy` low.
- R6: A non-inhibited request offered while `busy` is high is refused and marked as waiting. `retry_pulse` is then high for exactly one cycle: the first cycle in which `busy` is low.
- R7: While `retry_pulse` is high, every non-inhibited request is refused, even though `busy` is low.
- R8: A request with `req_inhibit` high is always accepted. It does not raise `fwd_valid` and does not change `busy`.
- R9: `fwd_valid` is high in the acceptance cycle exactly when the accepted request is not inhibited and `req_needs_resp` is high. In that cycle `fwd_cmd` and `fwd_size` equal `req_cmd` and `req_size`.
- R10: After synchronous reset, `busy` and `retry_pulse` are low and a plain request is accepted.
- R11: `retry_pulse` is never high in a cycle where `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is offered this cycle |
| req_cmd | input | 2 | 0 read, 1 write, 2 control, 3 message |
| req_size | input | SIZE_W | Transfer length in bytes |
| req_inhibit | input | 1 | Data is supplied by another agent |
| req_needs_resp | input | 1 | Request expects a reply |
| req_accept | output | 1 | Request taken this cycle |
| retry_pulse | output | 1 | One-cycle invitation to the waiting requester |
| busy | output | 1 | Throttle window active |
| fwd_valid | output | 1 | Request handed to the response path |
| fwd_cmd | output | 2 | Forwarded command |
| fwd_size | output | SIZE_W | Forwarded byte count |

## Verification
Reads and writes of several sizes are offered. These include size zero, which separates the no-busy case from a one-byte window. A size whose product overflows the countdown is also offered, and its observed busy length separates capping from wrap-around. Control and message commands separate the data path from the untimed commands. The bench offers requests on the last busy cycle, during the retry cycle and in the cycle after it. These place the boundary between "marked waiting", "blocked by the promised retry" and "free again". Inhibited requests are mixed into busy windows to show that they neither extend the window nor disturb the waiting flag. Every cycle is compared against a behavioural model.

// File: rtl/thr_pkg.sv
package thr_pkg;

    // Command codes seen on req_cmd; the data-moving ones are throttled.
    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_WR  = 2'd1,
        CMD_CTL = 2'd2,
        CMD_MSG = 2'd3
    } cmd_e;

    // Outcome of the admission decision for one cycle.
    typedef struct packed {
        logic take;        // request is accepted
        logic load;        // start a busy window
        logic mark_wait;   // refused because busy; remember requester
        logic fwd;         // hand to response path
    } admit_t;

    function automatic logic moves_data(cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

    function automatic bit is_pow2(int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic int unsigned bits_for(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/thr_duration.sv
module thr_duration
    import thr_pkg::*;
#(
    parameter int unsigned SIZE_W = 8,
    parameter int unsigned CPB    = 3,
    parameter int unsigned CNT_W  = 9
) (
    input  logic [SIZE_W-1:0] size,
    output logic [CNT_W-1:0]  dur,
    output logic              dur_nz
);
    localparam int unsigned CPB_W  = bits_for(CPB);
    localparam int unsigned PROD_W = SIZE_W + CPB_W;

    logic [PROD_W-1:0] prod;

    // Pick the cheapest product form for the configured rate.
    generate
        if (CPB == 0) begin : g_free
            logic unused_size;
            assign unused_size = ^size;
            assign prod = '0;
        end else if (is_pow2(CPB)) begin : g_shift
            assign prod = PROD_W'(size) << $clog2(CPB);
        end else begin : g_mult
            assign prod = PROD_W'(size) * PROD_W'(CPB);
        end
    endgenerate

    // Cap at the largest count the timer can hold.
    generate
        if (PROD_W > CNT_W) begin : g_sat
            assign dur = (|prod[PROD_W-1:CNT_W]) ? {CNT_W{1'b1}} : prod[CNT_W-1:0];
        end else begin : g_fit
            assign dur = CNT_W'(prod);
        end
    endgenerate

    assign dur_nz = |dur;

endmodule

// File: rtl/thr_gate.sv
module thr_gate
    import thr_pkg::*;
(
    input  logic   valid,
    input  cmd_e   cmd,
    input  logic   inhibit,
    input  logic   needs_resp,
    input  logic   busy,
    input  logic   pend,
    input  logic   dur_nz,
    output admit_t decision
);
    logic free;

    always_comb begin
        free     = !busy && !pend;
        decision = '0;
        if (valid) begin
            if (inhibit) begin
                // another agent supplies the data: swallow it
                decision.take = 1'b1;
            end else if (free) begin
                decision.take = 1'b1;
                decision.load = moves_data(cmd) && dur_nz;
                decision.fwd  = needs_resp;
            end else if (busy) begin
                decision.mark_wait = 1'b1;
            end
        end
    end

endmodule

// File: rtl/thr_timer.sv
module thr_timer #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/thr_retry.sv
module thr_retry (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic mark_wait,
    output logic pend,
    output logic retry
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (mark_wait) begin
            pend_q <= 1'b1;
        end else if (pend_q && !busy) begin
            pend_q <= 1'b0;   // retry issued this cycle
        end
    end

    assign pend  = pend_q;
    assign retry = pend_q && !busy;

endmodule

// File: rtl/throttle_admit.sv
module throttle_admit
    import thr_pkg::*;
#(
    parameter int unsigned SIZE_W = 8,
    parameter int unsigned CPB    = 3,
    parameter int unsigned CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_inhibit,
    input  logic              req_needs_resp,
    output logic              req_accept,
    output logic              retry_pulse,
    output logic              busy,
    output logic              fwd_valid,
    output logic [1:0]        fwd_cmd,
    output logic [SIZE_W-1:0] fwd_size
);
    logic [CNT_W-1:0] dur;
    logic             dur_nz;
    logic             pend;
    admit_t           dec;
    cmd_e             cmd;

    assign cmd = cmd_e'(req_cmd);

    thr_duration #(.SIZE_W(SIZE_W), .CPB(CPB), .CNT_W(CNT_W)) u_dur (
        .size   (req_size),
        .dur    (dur),
        .dur_nz (dur_nz)
    );

    thr_gate u_gate (
        .valid      (req_valid),
        .cmd        (cmd),
        .inhibit    (req_inhibit),
        .needs_resp (req_needs_resp),
        .busy       (busy),
        .pend       (pend),
        .dur_nz     (dur_nz),
        .decision   (dec)
    );

    thr_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (dec.load),
        .load_val (dur),
        .busy     (busy)
    );

    thr_retry u_retry (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .mark_wait (dec.mark_wait),
        .pend      (pend),
        .retry     (retry_pulse)
    );

    assign req_accept = dec.take;
    assign fwd_valid  = dec.fwd;
    assign fwd_cmd    = req_cmd;
    assign fwd_size   = req_size;

endmodule

// File: rtl/thr_checker.sv
module thr_checker #(
    parameter int unsigned SIZE_W = 8,
    parameter int unsigned CPB    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_cmd,
    input logic [SIZE_W-1:0] req_size,
    input logic              req_inhibit,
    input logic              req_accept,
    input logic              retry_pulse,
    input logic              busy,
    input logic              fwd_valid
);
    // R1
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_inhibit && busy) |-> !req_accept);

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (req_accept && !req_inhibit && req_cmd[1] == 1'b0 && req_size != '0 && CPB != 0)
        |=> busy);

    // R5
    ctl_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (req_accept && !req_inhibit && req_cmd[1] && !busy) |=> !busy);

    // R6
    retry_single_chk: assert property (@(posedge clk) disable iff (rst)
        retry_pulse |=> !retry_pulse);

    // R6
    retry_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        retry_pulse |-> $past(busy));

    // R7
    retry_block_chk: assert property (@(posedge clk) disable iff (rst)
        (retry_pulse && req_valid && !req_inhibit) |-> !req_accept);

    // R8
    inhibit_take_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_inhibit) |-> (req_accept && !fwd_valid));

    // R9
    fwd_accept_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (req_accept && !req_inhibit));

    // R11
    retry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        retry_pulse |-> !busy);

endmodule

bind throttle_admit thr_checker #(.SIZE_W(SIZE_W), .CPB(CPB)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_cmd     (req_cmd),
    .req_size    (req_size),
    .req_inhibit (req_inhibit),
    .req_accept  (req_accept),
    .retry_pulse (retry_pulse),
    .busy        (busy),
    .fwd_valid   (fwd_valid)
);

// File: tb/throttle_admit_test.sv
module throttle_admit_test;
    localparam int SIZE_W = 8;
    localparam int CPB    = 3;
    localparam int CNT_W  = 9;
    localparam int DMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_cmd = 2'd0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              req_inhibit = 1'b0;
    logic              req_needs_resp = 1'b0;
    logic              req_accept, retry_pulse, busy, fwd_valid;
    logic [1:0]        fwd_cmd;
    logic [SIZE_W-1:0] fwd_size;

    always #2 clk = ~clk;

    throttle_admit #(.SIZE_W(SIZE_W), .CPB(CPB), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_size(req_size), .req_inhibit(req_inhibit),
        .req_needs_resp(req_needs_resp), .req_accept(req_accept),
        .retry_pulse(retry_pulse), .busy(busy), .fwd_valid(fwd_valid),
        .fwd_cmd(fwd_cmd), .fwd_size(fwd_size)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt = 0;
    int m_wait = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive, compare against model, advance model.
    task automatic step(input bit v, input int c, input int s, input bit inh, input bit nr);
        int  dur;
        bit  e_busy, e_retry, e_acc, e_fwd;
        @(negedge clk);
        req_valid = v; req_cmd = 2'(c); req_size = SIZE_W'(s);
        req_inhibit = inh; req_needs_resp = nr;
        #1;
        dur     = (s * CPB > DMAX) ? DMAX : s * CPB;
        e_busy  = (m_cnt != 0);
        e_retry = (m_wait != 0) && !e_busy;
        e_acc   = v && (inh || (!e_busy && m_wait == 0));
        e_fwd   = e_acc && !inh && nr;
        chk(req_accept == e_acc, "R1 accept", int'(req_accept), int'(e_acc));
        chk(busy == e_busy, "R2 busy", int'(busy), int'(e_busy));
        chk(retry_pulse == e_retry, "R6 retry", int'(retry_pulse), int'(e_retry));
        chk(fwd_valid == e_fwd, "R9 fwd_valid", int'(fwd_valid), int'(e_fwd));
        if (e_fwd) begin
            chk(fwd_cmd == 2'(c), "R9 fwd_cmd", int'(fwd_cmd), c);
            chk(fwd_size == SIZE_W'(s), "R9 fwd_size", int'(fwd_size), s);
        end
        if (e_acc && !inh && c <= 1 && dur > 0) m_cnt = dur;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        if (v && !inh && e_busy) m_wait = 1;
        else if (m_wait != 0 && !e_busy) m_wait = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
    endtask

    initial begin
        int run;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state and first plain request
        #1;
        chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
        chk(retry_pulse == 1'b0, "R10 retry after reset", int'(retry_pulse), 0);
        step(1, 2, 5, 0, 1);
        chk(req_accept == 1'b1, "R10 first accept", int'(req_accept), 1);

        // R5: control and message commands start no window
        step(1, 3, 40, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(busy == 1'b0, "R5 no busy after ctl/msg", int'(busy), 0);

        // R4: zero-size read
        step(1, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        chk(busy == 1'b0, "R4 zero duration", int'(busy), 0);

        // R2/R6: write of 4 bytes = 12 cycles; R8 inhibited during window
        step(1, 1, 4, 0, 0);
        step(1, 0, 9, 1, 1);
        chk(req_accept && !fwd_valid, "R8 inhibit during busy", int'(req_accept), 1);
        idle(3);
        step(1, 0, 2, 0, 1);               // refused, marks waiting
        chk(!req_accept, "R6 refused while busy", int'(req_accept), 0);
        idle(6);
        step(0, 0, 0, 0, 0);               // last busy cycle
        chk(busy == 1'b1, "R2 last busy cycle", int'(busy), 1);
        step(1, 1, 1, 0, 1);               // retry cycle: blocked
        chk(retry_pulse && !busy, "R11 retry without busy", int'(retry_pulse), 1);
        chk(!req_accept, "R7 blocked during retry", int'(req_accept), 0);
        step(1, 1, 1, 0, 1);               // free again, 3-cycle window
        chk(!retry_pulse, "R6 single pulse", int'(retry_pulse), 0);
        idle(5);

        // request on the last busy cycle of a 1-byte read
        step(1, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(1, 2, 3, 0, 1);               // busy, last cycle: marks waiting
        step(1, 2, 3, 1, 0);               // retry cycle, inhibited still taken
        chk(req_accept == 1'b1, "R8 inhibit during retry", int'(req_accept), 1);
        idle(2);

        // R3: saturated duration 200*3 -> capped
        step(1, 0, 200, 0, 1);
        run = 0;
        for (int k = 0; k < 700; k++) begin
            step(k % 37 == 0, 2, k % 7, k % 2, 1);
            if (busy) run++;
            if (!busy && m_wait == 0 && run > 0) break;
        end
        chk(run == DMAX, "R3 capped window length", run, DMAX);
        idle(4);

        // mixed traffic
        for (int k = 0; k < 300; k++)
            step((k % 3) != 0, k % 4, (k * 7) % 9, (k % 11) == 0, k % 2);
        idle(40);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule